// File: doc/BRIEF.md
# Delay-Slot Next-Fetch-Address Unit

This block picks the next two fetch addresses for a pipeline that executes one instruction after every branch (the delay slot). For each valid instruction it receives the current fetch address and its two sequential successors, a sign-extended branch displacement, an annul bit and a branch kind. From these it decides whether the branch is taken and registers the new pair of successor addresses together with a taken flag.

Two branch families are resolved. Condition-code branches evaluate a 4-bit condition over one of two flag sets, the 32-bit set or the 64-bit set. Register branches compare a 64-bit register value, read as signed, against zero. A branch that is not taken with its annul bit set skips the delay-slot instruction by moving the successor pair forward one extra slot. Register-branch encodings that are reserved raise an illegal-instruction flag and leave the sequence sequential.

The unit sits between the decode stage and the fetch address register. Fetch, displacement extraction and flag generation are done elsewhere.

Top module: `delay_slot_nextpc`

## Requirements
- R1: While reset is asserted (rstN low) nextNpc, nextNnpc, taken and illegalInst are all zero.
- R2: When instValid is low at a rising edge, all four outputs keep their previous values whatever the other inputs do.
- R3: A taken branch sets nextNnpc to curPc plus disp (modulo 2^ADDR_W), nextNpc to curNpc, and taken to 1; the annul bit has no effect on a taken branch.
- R4: A not-taken branch (brKind 1 or 2, not illegal) with annul set gives nextNpc equal to curNnpc and nextNnpc equal to curNnpc plus 4, with taken 0.
- R5: A not-taken branch with annul clear gives nextNpc equal to curNpc and nextNnpc equal to curNnpc, with taken 0.
- R6: For a condition-code branch (brKind 1), ccSub value 2 evaluates the condition on wideFlags; any other ccSub value (0 in normal use) evaluates it on narrowFlags. Each flag set is packed {N,Z,V,C} in bits 3 down to 0.
- R7: brCond encodes: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V; codes 8 to 15 are the logical complements of codes 0 to 7 (8 always, 9 not Z, and so on).
- R8: For a register branch (brKind 2), regCond with regVal read as signed two's complement: 1 equal zero, 2 less or equal zero, 3 less than zero, 5 not zero, 6 greater than zero, 7 greater or equal zero.
- R9: regCond 0 or 4 on a register branch sets illegalInst to 1, taken to 0, and gives the sequential pair (nextNpc = curNpc, nextNnpc = curNnpc) regardless of annul; illegalInst is 0 for every other instruction.
- R10: brKind 0 and 3 are non-branch instructions: taken 0, illegalInst 0, and the sequential pair, with annul and the condition inputs ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction strobe; outputs update only when high |
| brKind | input | 2 | 0 non-branch, 1 condition-code branch, 2 register branch, 3 non-branch |
| ccSub | input | 2 | Flag-set select: 2 wide set, otherwise narrow set |
| brCond | input | 4 | Condition code for condition-code branches |
| narrowFlags | input | 4 | 32-bit flag set {N,Z,V,C} |
| wideFlags | input | 4 | 64-bit flag set {N,Z,V,C} |
| regCond | input | 3 | Register test selector |
| regVal | input | REG_W | Register value compared against zero |
| annul | input | 1 | Skip delay slot when the branch is not taken |
| curPc | input | ADDR_W | Address of the branch |
| curNpc | input | ADDR_W | Sequential next address |
| curNnpc | input | ADDR_W | Sequential address after next |
| disp | input | ADDR_W | Sign-extended byte displacement |
| nextNpc | output | ADDR_W | Registered new next address |
| nextNnpc | output | ADDR_W | Registered new address after next |
| taken | output | 1 | Registered taken flag |
| illegalInst | output | 1 | Registered reserved-encoding flag |

## Verification
The hardest situation to reach from the ports is a wrong flag-set or a wrong condition that happens to produce the same address pair, since a not-taken branch without annul and a non-branch look identical. The stimulus therefore always drives the unselected flag set with the complement of the selected one and distinct, non-sequential values on curPc, curNpc and curNnpc, so every mis-selection shows up as a different address. All 16 conditions are swept against all 16 flag patterns on both sets with and without annul, and every register test is driven with zero, one, minus one and both signed extremes, including an address that wraps past the top of the space.

// File: rtl/nxp_pkg.sv
package nxp_pkg;

  typedef enum logic [1:0] {
    KIND_SEQ     = 2'd0,
    KIND_CC      = 2'd1,
    KIND_REG     = 2'd2,
    KIND_SEQ_ALT = 2'd3
  } brKind_e;

  // strobes from control to datapath; at most one is set
  typedef struct packed {
    logic takeBranch;
    logic skipSlot;
    logic illegal;
  } pcStrobe_t;

  localparam logic [1:0] CC_SUB_WIDE = 2'd2;

endpackage

// File: rtl/nxp_ctrl.sv
module nxp_ctrl
  import nxp_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  brKind_e          kind,
  input  logic [1:0]       ccSub,
  input  logic [3:0]       brCond,
  input  logic [3:0]       narrowFlags,
  input  logic [3:0]       wideFlags,
  input  logic [2:0]       regCond,
  input  logic [REG_W-1:0] regVal,
  input  logic             annul,
  output pcStrobe_t        strobe
);

  logic [3:0] selFlags;
  logic       ccHit;
  logic       regHit;
  logic       regReserved;
  logic       isBranch;
  logic       hit;
  logic       sgn;
  logic       isZero;

  function automatic logic condHolds(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cy, res;
    {n, z, v, cy} = f;
    unique case (c)
      4'h0: res = 1'b0;
      4'h1: res = z;
      4'h2: res = z | (n ^ v);
      4'h3: res = n ^ v;
      4'h4: res = cy | z;
      4'h5: res = cy;
      4'h6: res = n;
      4'h7: res = v;
      4'h8: res = 1'b1;
      4'h9: res = ~z;
      4'hA: res = ~(z | (n ^ v));
      4'hB: res = ~(n ^ v);
      4'hC: res = ~(cy | z);
      4'hD: res = ~cy;
      4'hE: res = ~n;
      default: res = ~v;
    endcase
    return res;
  endfunction

  assign selFlags = (ccSub == CC_SUB_WIDE) ? wideFlags : narrowFlags;
  assign ccHit    = condHolds(brCond, selFlags);

  assign sgn    = regVal[REG_W-1];
  assign isZero = (regVal == '0);

  always_comb begin
    regHit      = 1'b0;
    regReserved = 1'b0;
    unique case (regCond)
      3'd1: regHit = isZero;
      3'd2: regHit = sgn | isZero;
      3'd3: regHit = sgn;
      3'd5: regHit = ~isZero;
      3'd6: regHit = ~sgn & ~isZero;
      3'd7: regHit = ~sgn;
      default: regReserved = 1'b1;
    endcase
  end

  always_comb begin
    isBranch = 1'b0;
    hit      = 1'b0;
    strobe   = '0;
    unique case (kind)
      KIND_CC: begin
        isBranch = 1'b1;
        hit      = ccHit;
      end
      KIND_REG: begin
        isBranch       = ~regReserved;
        hit            = regHit;
        strobe.illegal = regReserved;
      end
      default: begin
        isBranch = 1'b0;
        hit      = 1'b0;
      end
    endcase
    strobe.takeBranch = isBranch & hit;
    strobe.skipSlot   = isBranch & ~hit & annul;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeBranch, strobe.skipSlot, strobe.illegal})); // R3
  AST_NEVER_COND: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_CC && brCond == 4'h0) |-> !strobe.takeBranch); // R7
  AST_ALWAYS_COND: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_CC && brCond == 4'h8) |-> strobe.takeBranch); // R7
  AST_RESERVED_RCOND: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_REG && regCond[1:0] == 2'b00) |-> (strobe.illegal && !strobe.skipSlot)); // R9
  AST_SEQ_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_SEQ || kind == KIND_SEQ_ALT) |-> (strobe == '0)); // R10

endmodule

// File: rtl/nxp_dpath.sv
module nxp_dpath
  import nxp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  pcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curNpc,
  input  logic [ADDR_W-1:0] curNnpc,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] nextNpc,
  output logic [ADDR_W-1:0] nextNnpc,
  output logic              taken,
  output logic              illegalInst
);

  localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(SLOT_BYTES);

  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] skipNnpc;
  logic [ADDR_W-1:0] npcD;
  logic [ADDR_W-1:0] nnpcD;

  assign target   = curPc + disp;
  assign skipNnpc = curNnpc + SLOT_STEP;

  always_comb begin
    npcD  = curNpc;
    nnpcD = curNnpc;
    if (strobe.takeBranch) begin
      nnpcD = target;
    end else if (strobe.skipSlot) begin
      npcD  = curNnpc;
      nnpcD = skipNnpc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextNpc     <= '0;
      nextNnpc    <= '0;
      taken       <= 1'b0;
      illegalInst <= 1'b0;
    end else if (instValid) begin
      nextNpc     <= npcD;
      nextNnpc    <= nnpcD;
      taken       <= strobe.takeBranch;
      illegalInst <= strobe.illegal;
    end
  end

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> ($stable(nextNpc) && $stable(nextNnpc) && $stable(taken) && $stable(illegalInst))); // R2
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && strobe.takeBranch) |=> (taken && nextNpc == $past(curNpc) && nextNnpc == $past(curPc) + $past(disp))); // R3
  AST_ANNUL_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && strobe.skipSlot) |=> (!taken && nextNpc == $past(curNnpc) && nextNnpc == nextNpc + SLOT_STEP)); // R4
  AST_ILLEGAL_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && strobe.illegal) |=> (illegalInst && !taken && nextNpc == $past(curNpc) && nextNnpc == $past(curNnpc))); // R9

endmodule

// File: rtl/delay_slot_nextpc.sv
module delay_slot_nextpc
  import nxp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 64,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        brKind,
  input  logic [1:0]        ccSub,
  input  logic [3:0]        brCond,
  input  logic [3:0]        narrowFlags,
  input  logic [3:0]        wideFlags,
  input  logic [2:0]        regCond,
  input  logic [REG_W-1:0]  regVal,
  input  logic              annul,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curNpc,
  input  logic [ADDR_W-1:0] curNnpc,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] nextNpc,
  output logic [ADDR_W-1:0] nextNnpc,
  output logic              taken,
  output logic              illegalInst
);

  pcStrobe_t strobe;

  nxp_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .kind       (brKind_e'(brKind)),
    .ccSub      (ccSub),
    .brCond     (brCond),
    .narrowFlags(narrowFlags),
    .wideFlags  (wideFlags),
    .regCond    (regCond),
    .regVal     (regVal),
    .annul      (annul),
    .strobe     (strobe)
  );

  nxp_dpath #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .strobe     (strobe),
    .curPc      (curPc),
    .curNpc     (curNpc),
    .curNnpc    (curNnpc),
    .disp       (disp),
    .nextNpc    (nextNpc),
    .nextNnpc   (nextNnpc),
    .taken      (taken),
    .illegalInst(illegalInst)
  );

endmodule

// File: tb/delay_slot_nextpc_bench.sv
`timescale 1ns/1ps
module delay_slot_nextpc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [1:0]  brKind = 2'd0;
  logic [1:0]  ccSub = 2'd0;
  logic [3:0]  brCond = 4'd0;
  logic [3:0]  narrowFlags = 4'd0;
  logic [3:0]  wideFlags = 4'd0;
  logic [2:0]  regCond = 3'd0;
  logic [63:0] regVal = '0;
  logic        annul = 1'b0;
  logic [63:0] curPc = '0;
  logic [63:0] curNpc = '0;
  logic [63:0] curNnpc = '0;
  logic [63:0] disp = '0;
  logic [63:0] nextNpc, nextNnpc;
  logic        taken, illegalInst;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  delay_slot_nextpc u_delay_slot_nextpc (
    .clk(clk), .rstN(rstN), .instValid(instValid), .brKind(brKind), .ccSub(ccSub),
    .brCond(brCond), .narrowFlags(narrowFlags), .wideFlags(wideFlags), .regCond(regCond),
    .regVal(regVal), .annul(annul), .curPc(curPc), .curNpc(curNpc), .curNnpc(curNnpc),
    .disp(disp), .nextNpc(nextNpc), .nextNnpc(nextNnpc), .taken(taken),
    .illegalInst(illegalInst)
  );

  // reference condition: low half computed, high half is its complement (R7)
  function automatic bit refCond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy, base;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c[2:0])
      3'd0: base = 0;
      3'd1: base = z;
      3'd2: base = z | (n ^ v);
      3'd3: base = n ^ v;
      3'd4: base = cy | z;
      3'd5: base = cy;
      3'd6: base = n;
      default: base = v;
    endcase
    return c[3] ? !base : base;
  endfunction

  function automatic bit refReg(input logic [2:0] r, input logic [63:0] val);
    longint s;
    s = $signed(val);
    case (r)
      3'd1: return s == 0;
      3'd2: return s <= 0;
      3'd3: return s < 0;
      3'd5: return s != 0;
      3'd6: return s > 0;
      3'd7: return s >= 0;
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [63:0] eNpc, input logic [63:0] eNnpc,
                         input bit eTaken, input bit eIll);
    checks++;
    if (nextNpc !== eNpc || nextNnpc !== eNnpc || taken !== eTaken || illegalInst !== eIll) begin
      failures++;
      $display("FAIL %s: got npc=%h nnpc=%h taken=%0b ill=%0b expected npc=%h nnpc=%h taken=%0b ill=%0b",
               tag, nextNpc, nextNnpc, taken, illegalInst, eNpc, eNnpc, eTaken, eIll);
    end
  endtask

  // drive is already set (at a negedge); clock it once and check at the following negedge
  task automatic stepCheck(input string tag);
    bit isBr, hit, ill;
    logic [63:0] eNpc, eNnpc;
    isBr = 0; hit = 0; ill = 0;
    if (brKind == 2'd1) begin
      isBr = 1;
      hit = refCond(brCond, (ccSub == 2'd2) ? wideFlags : narrowFlags);
    end else if (brKind == 2'd2) begin
      if (regCond == 3'd0 || regCond == 3'd4) ill = 1;
      else begin
        isBr = 1;
        hit = refReg(regCond, regVal);
      end
    end
    eNpc = curNpc; eNnpc = curNnpc;
    if (isBr && hit) eNnpc = curPc + disp;
    else if (isBr && annul) begin
      eNpc = curNnpc;
      eNnpc = curNnpc + 64'd4;
    end
    instValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare(tag, eNpc, eNnpc, isBr && hit, ill);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got no completion expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] vals[7];
    vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = '1;
    vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[5] = -64'sd5; vals[6] = 64'd42;

    // R1 reset state
    repeat (3) @(negedge clk);
    compare("R1", '0, '0, 0, 0);
    instValid = 1'b1;
    @(negedge clk);
    compare("R1", '0, '0, 0, 0);
    rstN = 1'b1;

    // R6 R7 with R3/R4/R5: full condition sweep on both flag sets
    brKind = 2'd1;
    for (int sub = 0; sub < 2; sub++) begin
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          for (int a = 0; a < 2; a++) begin
            ccSub = (sub == 1) ? 2'd2 : 2'd0;
            brCond = 4'(c);
            if (sub == 1) begin wideFlags = 4'(f); narrowFlags = ~4'(f); end
            else begin narrowFlags = 4'(f); wideFlags = ~4'(f); end
            annul = a[0];
            curPc = 64'h0000_1000 + 64'(c * 256 + f * 8);
            curNpc = curPc + 64'd4;
            curNnpc = curPc + 64'h40;
            disp = (f[0]) ? -64'sd96 : 64'(c * 16 + 32);
            stepCheck(sub == 1 ? "R6/R7" : "R7/R3/R4/R5");
          end
        end
      end
    end

    // R3 wrap-around of the target address
    brCond = 4'h8; ccSub = 2'd0; annul = 1'b1;
    curPc = 64'hFFFF_FFFF_FFFF_FFF8; curNpc = 64'hFFFF_FFFF_FFFF_FFFC;
    curNnpc = 64'h0; disp = 64'h20;
    stepCheck("R3");
    // R4 wrap of the skipped slot
    brCond = 4'h0; curNnpc = 64'hFFFF_FFFF_FFFF_FFFC;
    stepCheck("R4");

    // R8 R9 register branches
    brKind = 2'd2;
    for (int r = 0; r < 8; r++) begin
      for (int v = 0; v < 7; v++) begin
        for (int a = 0; a < 2; a++) begin
          regCond = 3'(r);
          regVal = vals[v];
          annul = a[0];
          curPc = 64'h0004_0000 + 64'(r * 64 + v * 4);
          curNpc = curPc + 64'd4;
          curNnpc = curPc + 64'h100;
          disp = (v[0]) ? 64'h800 : -64'sd2048;
          stepCheck((r == 0 || r == 4) ? "R9" : "R8");
        end
      end
    end

    // R10 non-branch kinds ignore annul and conditions
    for (int k = 0; k < 2; k++) begin
      brKind = (k == 0) ? 2'd0 : 2'd3;
      brCond = 4'h8; regCond = 3'd0; annul = 1'b1;
      curPc = 64'h9000; curNpc = 64'h9010; curNnpc = 64'h9020; disp = 64'h400;
      stepCheck("R10");
      brCond = 4'h0;
      stepCheck("R10");
    end

    // R2 hold while instValid is low
    brKind = 2'd1; brCond = 4'h8; annul = 1'b0; ccSub = 2'd0;
    curPc = 64'hA000; curNpc = 64'hA004; curNnpc = 64'hA008; disp = 64'h10;
    stepCheck("R3");
    for (int i = 0; i < 4; i++) begin
      instValid = 1'b0;
      brKind = 2'd2; regCond = 3'd4;
      curPc = 64'(i * 1000 + 7); curNpc = 64'(i * 3); curNnpc = 64'(i * 5 + 1);
      @(posedge clk);
      @(negedge clk);
      compare("R2", 64'hA004, 64'hA010, 1, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule